// File: doc/BRIEF.md
# Voltage Ramp Safety Controller

This controller runs one voltage-scaling cycle for a core supply. A start pulse hands it a target setpoint code. It then walks its setpoint toward that code in fixed strides, up or down. Each stride waits for the regulator side to accept it. Once the setpoint equals the target, the controller takes one sample of the measured core voltage and die temperature. It checks both against safe windows and ends the cycle with either a success pulse or a failure pulse that carries a reason code.

The setpoint code and the voltage measurement share one scale: 1 LSB = 5 mV, so code 250 = 1.25 V. The default stride is 2 codes (10 mV). The temperature code is degrees Celsius plus 64, so code 24 = -40 °C and code 194 = 130 °C. The serial link to the regulator and the sensors sit outside this block.

Top module: `vramp_guard`

## Requirements
- R1: After reset, set_code = INIT_CODE (250), and step_req, done, fail and fail_why are all 0.
- R2: A start pulse while idle latches target and clears fail_why to 2'b00. From the next cycle on, step_req is high exactly while the ramp phase is active and set_code differs from the latched target.
- R3: In a cycle with step_req and step_ack both high, set_code moves toward the target by STEP codes, or by the remaining distance when that is smaller, so it never passes the target. In any other cycle, step_ack has no effect and set_code holds.
- R4: Ramping works in both directions. The number of accepted steps in a cycle is ceil(|target - start setpoint| / STEP).
- R5: One cycle after set_code reaches the target, v_meas and t_meas are sampled once. The windows are inclusive: v_meas must lie in [230, 260] (1.15 V to 1.30 V) and t_meas in [24, 194] (-40 °C to 130 °C). If both are in window, done is high on the following cycle.
- R6: A v_meas outside its window ends the cycle with fail high and fail_why = 2'b01. Voltage takes priority when both readings are bad.
- R7: A t_meas outside its window, with v_meas in window, ends the cycle with fail high and fail_why = 2'b10. For example, code 209 (145 °C) fails.
- R8: start is ignored while a cycle is in progress, including the cycle in which done is high. The latched target does not change.
- R9: fail_why keeps its value until the next accepted start.
- R10: done and fail are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scaling cycle (taken only when idle) |
| target | input | CODE_W | Requested setpoint code |
| v_meas | input | CODE_W | Measured core voltage code |
| t_meas | input | TEMP_W | Measured temperature code (°C + 64) |
| step_ack | input | 1 | Regulator accepts the pending step |
| set_code | output | CODE_W | Current setpoint code |
| step_req | output | 1 | A step is pending |
| done | output | 1 | Cycle finished in window (one-cycle pulse) |
| fail | output | 1 | Cycle aborted on a window violation (one-cycle pulse) |
| fail_why | output | 2 | 01 voltage, 10 temperature, 00 none |

## Verification
The assertions assume that every input is a known value at each sampling edge. They also assume step_ack may arrive in any cycle, including cycles with no step pending, so its effect is checked only through step_req. The stimulus sets all inputs at the falling edge from defined values and keeps the readings constant through a whole cycle. It also raises step_ack at random whether or not a request is pending, and places start pulses inside a running cycle and on the cycle where done is high.

// File: rtl/vramp_guard.sv
module vramp_guard #(
  parameter int CODE_W    = 9,
  parameter int TEMP_W    = 8,
  parameter int STEP      = 2,
  parameter int INIT_CODE = 250,
  parameter int V_LO      = 230,
  parameter int V_HI      = 260,
  parameter int T_LO      = 24,
  parameter int T_HI      = 194
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] target,
  input  logic [CODE_W-1:0] v_meas,
  input  logic [TEMP_W-1:0] t_meas,
  input  logic              step_ack,
  output logic [CODE_W-1:0] set_code,
  output logic              step_req,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fail_why
);
  localparam logic [CODE_W-1:0] STEP_C = CODE_W'(STEP);
  localparam logic [CODE_W-1:0] INIT_C = CODE_W'(INIT_CODE);
  localparam logic [CODE_W-1:0] VLO_C  = CODE_W'(V_LO);
  localparam logic [CODE_W-1:0] VHI_C  = CODE_W'(V_HI);
  localparam logic [TEMP_W-1:0] TLO_C  = TEMP_W'(T_LO);
  localparam logic [TEMP_W-1:0] THI_C  = TEMP_W'(T_HI);

  typedef enum logic [1:0] {S_START, S_RAMP, S_PARK, S_SAFE} phase_t;
  phase_t            phase;
  logic [CODE_W-1:0] tgt;

  logic              going_up;
  logic [CODE_W-1:0] gap, stride, stepped;
  logic              v_bad, t_bad;

  assign going_up = tgt > set_code;
  assign gap      = going_up ? tgt - set_code : set_code - tgt;
  assign stride   = (gap > STEP_C) ? STEP_C : gap;
  assign stepped  = going_up ? set_code + stride : set_code - stride;

  assign v_bad = (v_meas < VLO_C) || (v_meas > VHI_C);
  assign t_bad = (t_meas < TLO_C) || (t_meas > THI_C);

  assign step_req = (phase == S_RAMP) && (set_code != tgt);
  assign done     = (phase == S_SAFE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= S_START;
      tgt      <= INIT_C;
      set_code <= INIT_C;
      fail     <= 1'b0;
      fail_why <= 2'b00;
    end else begin
      fail <= 1'b0;
      case (phase)
        S_START: if (start) begin
          tgt      <= target;
          fail_why <= 2'b00;
          phase    <= S_RAMP;
        end
        S_RAMP: begin
          if (set_code == tgt) phase <= S_PARK;
          else if (step_ack)   set_code <= stepped;
        end
        S_PARK: begin
          if (v_bad) begin
            fail     <= 1'b1;
            fail_why <= 2'b01;
            phase    <= S_START;
          end else if (t_bad) begin
            fail     <= 1'b1;
            fail_why <= 2'b10;
            phase    <= S_START;
          end else begin
            phase <= S_SAFE;
          end
        end
        default: phase <= S_START;
      endcase
    end
  end
endmodule

module vramp_guard_chk #(
  parameter int CODE_W = 9,
  parameter int STEP   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] set_code,
  input logic [CODE_W-1:0] tgt,
  input logic              step_req,
  input logic              step_ack,
  input logic              done,
  input logic              fail,
  input logic [1:0]        fail_why
);
  assert_hold_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_req && step_ack) |=> $stable(set_code));

  assert_up_no_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && step_ack && set_code < tgt) |=>
      (set_code > $past(set_code)) && (set_code <= $past(tgt)) &&
      (set_code - $past(set_code) <= CODE_W'(STEP)));

  assert_down_no_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && step_ack && set_code > tgt) |=>
      (set_code < $past(set_code)) && (set_code >= $past(tgt)) &&
      ($past(set_code) - set_code <= CODE_W'(STEP)));

  assert_excl_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

  assert_fail_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (fail_why == 2'b01 || fail_why == 2'b10));

  assert_reason_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_why != 2'b00 && !fail) |=> (fail_why == $past(fail_why)) || (fail_why == 2'b00));
endmodule

bind vramp_guard vramp_guard_chk #(.CODE_W(CODE_W), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_code(set_code), .tgt(tgt),
  .step_req(step_req), .step_ack(step_ack), .done(done), .fail(fail),
  .fail_why(fail_why)
);

// File: tb/vramp_guard_test.sv
module vramp_guard_test;
  localparam int STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] target = '0;
  logic [8:0] v_meas = 9'd250;
  logic [7:0] t_meas = 8'd100;
  logic       step_ack = 1'b0;
  logic [8:0] set_code;
  logic       step_req, done, fail;
  logic [1:0] fail_why;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  vramp_guard uut (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .v_meas(v_meas), .t_meas(t_meas), .step_ack(step_ack),
    .set_code(set_code), .step_req(step_req), .done(done),
    .fail(fail), .fail_why(fail_why)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int toward(input int from, input int to);
    if (from < to) return from + ((to - from) > STEP ? STEP : (to - from));
    if (from > to) return from - ((from - to) > STEP ? STEP : (from - to));
    return from;
  endfunction

  function automatic int steps_needed(input int from, input int to);
    int d = (from > to) ? from - to : to - from;
    return (d + STEP - 1) / STEP;
  endfunction

  function automatic int verdict(input int v, input int t);
    if (v < 230 || v > 260) return 1;
    if (t < 24 || t > 194) return 2;
    return 0;
  endfunction

  task automatic run(input int tgt, input int v, input int t, input bit intrude,
                     input bit poke_safe);
    int expc, nxt, steps, first, exp_v;
    bit rnd, acc;
    v_meas = 9'(v);
    t_meas = 8'(t);
    first  = set_code;
    start  = 1'b1;
    target = 9'(tgt);
    @(negedge clk);
    start = 1'b0;
    chk(fail_why == 2'b00, "R2 reason cleared on start", fail_why, 0);
    chk(step_req == (first != tgt), "R2 step_req after start", step_req, first != tgt);
    expc  = set_code;
    steps = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done || fail) break;
      rnd = ($urandom % 3) != 0;
      acc = rnd && step_req;
      nxt = acc ? toward(expc, tgt) : expc;
      step_ack = rnd;
      if (intrude && i == 1) begin
        start  = 1'b1;
        target = 9'(tgt ^ 9'h0f5);
      end
      @(negedge clk);
      step_ack = 1'b0;
      start = 1'b0;
      if (acc) steps++;
      chk(set_code == nxt, acc ? "R3 stride toward target" : "R3 hold without accepted step",
          set_code, nxt);
      expc = nxt;
    end
    chk(set_code == tgt, intrude ? "R8 start ignored mid-cycle" : "R4 setpoint reaches target",
        set_code, tgt);
    chk(steps == steps_needed(first, tgt), "R4 step count", steps, steps_needed(first, tgt));
    exp_v = verdict(v, t);
    if (exp_v == 0) begin
      chk(done && !fail, "R5 success pulse", {done, fail}, 2);
    end else begin
      chk(fail && !done, exp_v == 1 ? "R6 fail pulse" : "R7 fail pulse", {done, fail}, 1);
      chk(fail_why == 2'(exp_v), exp_v == 1 ? "R6 reason voltage" : "R7 reason temperature",
          fail_why, exp_v);
    end
    if (poke_safe && done) begin
      start  = 1'b1;
      target = 9'(tgt ^ 9'h011);
      @(negedge clk);
      start = 1'b0;
      chk(!step_req && !done && !fail, "R8 start during done ignored", step_req, 0);
    end else begin
      @(negedge clk);
      chk(!done && !fail, "R10 single-cycle pulse", {done, fail}, 0);
    end
    repeat (2) @(negedge clk);
    chk(fail_why == 2'(exp_v), "R9 reason held", fail_why, exp_v);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(set_code == 9'd250, "R1 reset setpoint", set_code, 250);
    chk(!step_req && !done && !fail && fail_why == 2'b00, "R1 reset outputs",
        {step_req, done, fail, fail_why}, 0);

    run(300, 250, 100, 0, 0);
    run(201, 250, 100, 0, 0);
    run(201, 250, 100, 0, 0);
    run(206, 230, 24, 0, 1);
    run(213, 260, 194, 0, 0);
    run(240, 229, 100, 0, 0);
    run(245, 261, 100, 0, 0);
    run(250, 250, 209, 0, 0);
    run(255, 250, 23, 0, 0);
    run(260, 200, 209, 0, 0);
    run(180, 250, 100, 1, 0);
    run(321, 245, 150, 1, 1);

    for (int k = 0; k < 40; k++) begin
      run(150 + int'($urandom % 200), 220 + int'($urandom % 51),
          10 + int'($urandom % 201), ($urandom % 4) == 0, ($urandom % 3) == 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule